// File: doc/BRIEF.md
# Host-Transport UART with RTS/CTS Flow Control

This block is a byte-serial link for carrying a host transport over a two-wire data path with two flow-control wires. The processor writes bytes into a transmit queue and reads received bytes from a receive queue. Both queues are deep. The processor also picks a line rate from a fixed menu and sets two fill levels that drive the interrupt lines and the RTS pin. Every character uses one start bit, eight data bits sent least significant bit first, no parity and one stop bit.

A fractional phase accumulator runs on the system clock (13 MHz by default) and produces an oversampling tick at OVS times the selected line rate. The transmitter counts OVS ticks per bit. The receiver looks for a low level on the tick grid, checks that the line is still low in the middle of the start bit, and then samples every later bit at its centre. A new character is only started while CTS is high. The receiver drops RTS once its queue reaches the programmed level, which tells the peer to stop sending. TXD has an enable output that stays low for as long as reset is asserted.

The processor side is a small register port. The address is combinational for reads, and writes take effect on the clock edge. The registers are: 0 data (a write enqueues, a read dequeues), 1 rate select, 2 receive level, 3 transmit level, 4 status, 5 receive count, 6 transmit count.

Top module: `hci_uart`

## Requirements
- R1: While rst_n is low, txd_oe is 0. After reset, the rate register reads 6 (57.6 kbaud), both level registers read DEPTH/2, both counts read 0, rts is 1 and tx_irq is 1.
- R2: Each character is sent as a low start bit, eight data bits LSB first, and a high stop bit. With txd looped to rxd, every byte written is read back unchanged and in the same order.
- R3: Rate codes 0..19 select 921600, 460800, 230400, 153600, 115200, 76800, 57600, 38400, 28800, 19200, 14400, 9600, 7200, 4800, 2400, 1800, 1200, 900, 600 and 300 baud, and codes above 19 select 300 baud. Sending byte 0x00 holds txd low for 9 bit times of CLK_HZ/rate clocks each, within one tick period plus three clocks.
- R4: No character starts while cts is low. A character already in progress when cts falls is completed, and the next one waits until cts is high again.
- R5: rts is 0 while the receive count is at or above the receive level and 1 while it is below. A level of 0 means DEPTH.
- R6: rx_irq is 1 exactly when rts is 0. tx_irq is 1 while the transmit count is below the transmit level.
- R7: A write of a receive level above DEPTH-1 stores DEPTH-1. A write of a transmit level above DEPTH stores DEPTH.
- R8: A character that completes while the receive queue holds DEPTH bytes is dropped and sets status bit 3. Writing status with bit 3 set clears that bit. The queued bytes are not affected.
- R9: A low pulse on rxd that has ended by the middle of the start bit produces no character.
- R10: A data write while the transmit queue holds DEPTH bytes is ignored.
- R11: A data read while the receive queue is empty returns 0 and changes nothing. Status bits are: bit 0 receive queue not empty, bit 1 transmit queue full, bit 2 transmitter idle with an empty queue, bit 3 overrun, bit 4 synchronised cts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 0 dequeues) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Peer allows sending when 1 |
| txd | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Output enable for txd, 0 during reset |
| rts | output | 1 | 1 allows the peer to send |
| rx_irq | output | 1 | Receive level reached |
| tx_irq | output | 1 | Transmit queue below its level |

## Verification
The embedded assertions check four things on every cycle: a character never starts unless the synchronised cts was high, a starting character drives its start bit at once, rts is low whenever the receive queue is full, and the overrun flag only rises on a cycle when the queue was full. They also check that neither queue count goes past DEPTH. The bench scenarios are the only way to show the rest: that the bit timing matches each rate code, that bytes come back intact and in order through the loopback, that short glitches are rejected, that the level clamps hold, and that full-queue writes and empty-queue reads leave no trace.

// File: rtl/hci_uart.sv
module hci_uart #(
  parameter int CLK_HZ = 13_000_000,
  parameter int DEPTH  = 128,
  parameter int OVS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  input  logic       cts,
  output logic       txd,
  output logic       txd_oe,
  output logic       rts,
  output logic       rx_irq,
  output logic       tx_irq
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  function automatic logic [31:0] rate_of(input logic [4:0] s);
    case (s)
      5'd0:  rate_of = 32'd921600;
      5'd1:  rate_of = 32'd460800;
      5'd2:  rate_of = 32'd230400;
      5'd3:  rate_of = 32'd153600;
      5'd4:  rate_of = 32'd115200;
      5'd5:  rate_of = 32'd76800;
      5'd6:  rate_of = 32'd57600;
      5'd7:  rate_of = 32'd38400;
      5'd8:  rate_of = 32'd28800;
      5'd9:  rate_of = 32'd19200;
      5'd10: rate_of = 32'd14400;
      5'd11: rate_of = 32'd9600;
      5'd12: rate_of = 32'd7200;
      5'd13: rate_of = 32'd4800;
      5'd14: rate_of = 32'd2400;
      5'd15: rate_of = 32'd1800;
      5'd16: rate_of = 32'd1200;
      5'd17: rate_of = 32'd900;
      5'd18: rate_of = 32'd600;
      default: rate_of = 32'd300;
    endcase
  endfunction

  // configuration
  logic [4:0]    sel;
  logic [CW-1:0] rx_lvl_reg, tx_lvl_reg;
  logic          ovr;

  // tick generator
  logic [31:0] acc;
  logic        tick;
  logic [31:0] inc;
  logic [32:0] acc_sum;
  assign inc     = rate_of(sel) * 32'(OVS);
  assign acc_sum = {1'b0, acc} + {1'b0, inc};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (acc_sum >= 33'(CLK_HZ)) begin
      acc  <= 32'(acc_sum - 33'(CLK_HZ));
      tick <= 1'b1;
    end else begin
      acc  <= acc_sum[31:0];
      tick <= 1'b0;
    end

  // input synchronisers
  logic [1:0] rx_sy, cts_sy;
  logic rx_s, cts_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sy  <= 2'b11;
      cts_sy <= 2'b00;
    end else begin
      rx_sy  <= {rx_sy[0], rxd};
      cts_sy <= {cts_sy[0], cts};
    end
  assign rx_s  = rx_sy[1];
  assign cts_s = cts_sy[1];

  // transmit queue
  logic [7:0]    tmem [DEPTH];
  logic [AW-1:0] twp, trp;
  logic [CW-1:0] tcnt;
  logic          tbusy;
  logic          tx_push, tx_start;
  assign tx_push  = wr_en && addr == 3'd0 && tcnt != CW'(DEPTH);
  assign tx_start = !tbusy && tcnt != '0 && cts_s;

  always_ff @(posedge clk)
    if (tx_push) tmem[twp] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      twp  <= '0;
      trp  <= '0;
      tcnt <= '0;
    end else begin
      if (tx_push)  twp <= twp + 1'b1;
      if (tx_start) trp <= trp + 1'b1;
      tcnt <= tcnt + CW'(tx_push) - CW'(tx_start);
    end

  // transmitter
  logic [9:0]    tsh;
  logic [3:0]    tbit;
  logic [PW-1:0] tph;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tsh   <= '1;
      tbit  <= '0;
      tph   <= '0;
      tbusy <= 1'b0;
    end else if (tx_start) begin
      tsh   <= {1'b1, tmem[trp], 1'b0};
      tbit  <= '0;
      tph   <= '0;
      tbusy <= 1'b1;
    end else if (tbusy && tick) begin
      if (tph == PW'(OVS - 1)) begin
        tph <= '0;
        tsh <= {1'b1, tsh[9:1]};
        if (tbit == 4'd9) tbusy <= 1'b0;
        else              tbit  <= tbit + 1'b1;
      end else begin
        tph <= tph + 1'b1;
      end
    end
  assign txd = tbusy ? tsh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) txd_oe <= 1'b0;
    else        txd_oe <= 1'b1;

  // receiver
  logic          rbusy;
  logic [PW-1:0] rph;
  logic [3:0]    rbit;
  logic [7:0]    rsh;
  logic          rx_mid, rx_done;
  assign rx_mid  = tick && rbusy && rph == PW'(HALF);
  assign rx_done = rx_mid && rbit == 4'd9 && rx_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbusy <= 1'b0;
      rph   <= '0;
      rbit  <= '0;
      rsh   <= '0;
    end else if (tick) begin
      if (!rbusy) begin
        if (!rx_s) begin
          rbusy <= 1'b1;
          rph   <= PW'(1);
          rbit  <= '0;
        end
      end else begin
        rph <= (rph == PW'(OVS - 1)) ? '0 : rph + 1'b1;
        if (rx_mid) begin
          if (rbit == 4'd0) begin
            if (rx_s) rbusy <= 1'b0;
            else      rbit  <= 4'd1;
          end else if (rbit == 4'd9) begin
            rbusy <= 1'b0;
          end else begin
            rsh  <= {rx_s, rsh[7:1]};
            rbit <= rbit + 1'b1;
          end
        end
      end
    end

  // receive queue
  logic [7:0]    rmem [DEPTH];
  logic [AW-1:0] rwp, rrp;
  logic [CW-1:0] rcnt;
  logic          rx_full, rx_push, rx_pop;
  assign rx_full = rcnt == CW'(DEPTH);
  assign rx_push = rx_done && !rx_full;
  assign rx_pop  = rd_en && addr == 3'd0 && rcnt != '0;

  always_ff @(posedge clk)
    if (rx_push) rmem[rwp] <= rsh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rwp  <= '0;
      rrp  <= '0;
      rcnt <= '0;
    end else begin
      if (rx_push) rwp <= rwp + 1'b1;
      if (rx_pop)  rrp <= rrp + 1'b1;
      rcnt <= rcnt + CW'(rx_push) - CW'(rx_pop);
    end

  // registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel        <= 5'd6;
      rx_lvl_reg <= CW'(DEPTH / 2);
      tx_lvl_reg <= CW'(DEPTH / 2);
      ovr        <= 1'b0;
    end else begin
      if (wr_en && addr == 3'd1) sel <= wdata[4:0];
      if (wr_en && addr == 3'd2)
        rx_lvl_reg <= ({1'b0, wdata} > 9'(DEPTH - 1)) ? CW'(DEPTH - 1) : wdata[CW-1:0];
      if (wr_en && addr == 3'd3)
        tx_lvl_reg <= ({1'b0, wdata} > 9'(DEPTH)) ? CW'(DEPTH) : wdata[CW-1:0];
      if (rx_done && rx_full)                    ovr <= 1'b1;
      else if (wr_en && addr == 3'd4 && wdata[3]) ovr <= 1'b0;
    end

  logic [CW-1:0] rx_level;
  assign rx_level = (rx_lvl_reg == '0) ? CW'(DEPTH) : rx_lvl_reg;
  assign rx_irq   = rcnt >= rx_level;
  assign rts      = !rx_irq;
  assign tx_irq   = tcnt < tx_lvl_reg;

  always_comb
    case (addr)
      3'd0:    rdata = (rcnt != '0) ? rmem[rrp] : 8'h00;
      3'd1:    rdata = {3'b000, sel};
      3'd2:    rdata = 8'(rx_lvl_reg);
      3'd3:    rdata = 8'(tx_lvl_reg);
      3'd4:    rdata = {3'b000, cts_s, ovr, !tbusy && tcnt == '0, tcnt == CW'(DEPTH), rcnt != '0};
      3'd5:    rdata = 8'(rcnt);
      3'd6:    rdata = 8'(tcnt);
      default: rdata = 8'h00;
    endcase

  // R4: a character only starts after cts was seen high
  a_r4_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbusy) |-> $past(cts_s));
  // R2: start bit appears as soon as a character starts
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbusy) |-> !txd);
  // R5: a full receive queue always holds the peer off
  a_r5_rts_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rcnt == CW'(DEPTH)) |-> !rts);
  // R8: overrun only rises after the queue was full
  a_r8_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rcnt) == CW'(DEPTH));
  // R10: counts stay within the queue depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= CW'(DEPTH) && tcnt <= CW'(DEPTH));
endmodule

// File: tb/test_hci_uart.sv
module test_hci_uart;
  localparam int CLK_HZ = 13_000_000;
  localparam int DEPTH  = 8;
  localparam int OVS    = 8;
  localparam int BITC   = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic cts = 1'b1;
  logic txd, txd_oe, rts, rx_irq, tx_irq;
  logic bsel = 1'b0, brx = 1'b1;
  logic rxd_in;
  assign rxd_in = bsel ? brx : txd;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hci_uart #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH), .OVS(OVS)) i_hci_uart (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rxd(rxd_in), .cts(cts), .txd(txd),
    .txd_oe(txd_oe), .rts(rts), .rx_irq(rx_irq), .tx_irq(tx_irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, input bit pop, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = pop; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_raw(input logic [7:0] b);
    @(negedge clk); brx = 1'b0; idle(BITC);
    for (int i = 0; i < 8; i++) begin brx = b[i]; idle(BITC); end
    brx = 1'b1; idle(BITC);
  endtask

  function automatic int rate_of(input int s);
    int t [20] = '{921600, 460800, 230400, 153600, 115200, 76800, 57600, 38400,
                   28800, 19200, 14400, 9600, 7200, 4800, 2400, 1800, 1200, 900, 600, 300};
    return t[s];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp_q [$];
    idle(3);
    check(txd_oe == 1'b0, "R1 oe in reset", int'(txd_oe), 0);
    rst_n = 1'b1;
    idle(3);
    check(txd_oe == 1'b1, "R1 oe after reset", int'(txd_oe), 1);
    rreg(3'd1, 0, d); check(d == 8'd6, "R1 rate", d, 6);
    rreg(3'd2, 0, d); check(d == 8'(DEPTH/2), "R1 rx level", d, DEPTH/2);
    rreg(3'd3, 0, d); check(d == 8'(DEPTH/2), "R1 tx level", d, DEPTH/2);
    rreg(3'd5, 0, d); check(d == 0, "R1 rx count", d, 0);
    check(rts && tx_irq && !rx_irq, "R1 pins", {rts, tx_irq, rx_irq}, 3'b110);

    // R11: empty read
    rreg(3'd0, 1, d); check(d == 0, "R11 empty read", d, 0);
    rreg(3'd5, 0, d); check(d == 0, "R11 count after empty read", d, 0);
    rreg(3'd4, 0, d); check(d == 8'b0001_0100, "R11 status idle", d, 8'b0001_0100);

    // R2: loopback at fastest rate, several patterns
    wreg(3'd1, 8'd0);
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < DEPTH; i++) begin
        d = 8'((r * DEPTH + i) * 37 + 5 + r * 64);
        exp_q.push_back(d);
        wreg(3'd0, d);
      end
      idle(DEPTH * 160 + 200);
      rreg(3'd5, 0, d); check(d == DEPTH, "R2 count", d, DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        rreg(3'd0, 1, d); check(d == e, "R2 data", d, e);
      end
    end

    // R4: cts low blocks start
    cts = 1'b0;
    wreg(3'd0, 8'h5A);
    begin
      bit seen_low = 0;
      for (int i = 0; i < 1000; i++) begin @(negedge clk); if (!txd) seen_low = 1; end
      check(!seen_low, "R4 no start while cts low", int'(seen_low), 0);
    end
    rreg(3'd6, 0, d); check(d == 1, "R4 tx held", d, 1);
    cts = 1'b1; idle(300);
    rreg(3'd0, 1, d); check(d == 8'h5A, "R4 sent after cts", d, 8'h5A);

    // R4: cts falls mid-character
    wreg(3'd0, 8'h11); wreg(3'd0, 8'h22);
    while (txd) @(negedge clk);
    idle(20); cts = 1'b0; idle(800);
    rreg(3'd5, 0, d); check(d == 1, "R4 current finishes", d, 1);
    rreg(3'd6, 0, d); check(d == 1, "R4 next waits", d, 1);
    cts = 1'b1; idle(300);
    rreg(3'd0, 1, d); check(d == 8'h11, "R4 first", d, 8'h11);
    rreg(3'd0, 1, d); check(d == 8'h22, "R4 second", d, 8'h22);

    // R10, R6: tx queue full and tx level
    cts = 1'b0;
    wreg(3'd3, 8'd2); idle(1);
    check(tx_irq == 1'b1, "R6 tx irq at 0", int'(tx_irq), 1);
    wreg(3'd0, 8'h01); idle(1);
    check(tx_irq == 1'b1, "R6 tx irq at 1", int'(tx_irq), 1);
    wreg(3'd0, 8'h02); idle(1);
    check(tx_irq == 1'b0, "R6 tx irq at 2", int'(tx_irq), 0);
    for (int i = 2; i < DEPTH + 1; i++) wreg(3'd0, 8'(i + 1));
    rreg(3'd6, 0, d); check(d == DEPTH, "R10 full write ignored", d, DEPTH);
    rreg(3'd4, 0, d); check(d[1] == 1'b1, "R11 tx full bit", d[1], 1);
    wreg(3'd3, 8'd200);
    rreg(3'd3, 0, d); check(d == DEPTH, "R7 tx clamp", d, DEPTH);
    check(tx_irq == 1'b0, "R6 tx irq full", int'(tx_irq), 0);

    // R8: overrun, queue keeps first DEPTH bytes
    wreg(3'd2, 8'd0);
    cts = 1'b1; idle(DEPTH * 160 + 200);
    check(rts == 1'b0 && rx_irq == 1'b1, "R5 rts full", int'(rts), 0);
    wreg(3'd0, 8'hEE); idle(300);
    rreg(3'd5, 0, d); check(d == DEPTH, "R8 count", d, DEPTH);
    rreg(3'd4, 0, d); check(d[3] == 1'b1, "R8 overrun set", d[3], 1);
    for (int i = 0; i < DEPTH; i++) begin
      rreg(3'd0, 1, d); check(d == 8'(i + 1), "R8 kept data", d, i + 1);
    end
    wreg(3'd4, 8'h08);
    rreg(3'd4, 0, d); check(d[3] == 1'b0, "R8 overrun cleared", d[3], 0);

    // R5, R6, R7: rx level
    wreg(3'd2, 8'd200);
    rreg(3'd2, 0, d); check(d == DEPTH - 1, "R7 rx clamp", d, DEPTH - 1);
    wreg(3'd2, 8'd3);
    wreg(3'd0, 8'hA1); wreg(3'd0, 8'hA2); idle(400);
    check(rts == 1'b1 && rx_irq == 1'b0, "R5 below level", int'(rts), 1);
    wreg(3'd0, 8'hA3); idle(250);
    check(rts == 1'b0, "R5 at level", int'(rts), 0);
    check(rx_irq == 1'b1, "R6 rx irq at level", int'(rx_irq), 1);
    rreg(3'd0, 1, d); idle(1);
    check(rts == 1'b1 && rx_irq == 1'b0, "R5 back below", int'(rts), 1);
    rreg(3'd0, 1, d); rreg(3'd0, 1, d);
    check(d == 8'hA3, "R2 order", d, 8'hA3);

    // R9: short glitches rejected, then a real byte
    bsel = 1'b1;
    for (int w = 1; w <= 4; w++) begin
      @(negedge clk); brx = 1'b0; idle(w); brx = 1'b1; idle(300);
      rreg(3'd5, 0, d); check(d == 0, "R9 glitch", d, 0);
    end
    send_raw(8'hA5); idle(50);
    rreg(3'd0, 1, d); check(d == 8'hA5, "R9 real byte", d, 8'hA5);
    bsel = 1'b0;

    // R3: bit time per rate code
    for (int s = 0; s <= 12; s++) begin
      int cnt, expc, tol;
      wreg(3'd1, 8'(s));
      wreg(3'd0, 8'h00);
      while (txd) @(negedge clk);
      cnt = 0;
      while (!txd) begin cnt++; @(negedge clk); end
      expc = 9 * CLK_HZ / rate_of(s);
      tol = CLK_HZ / (rate_of(s) * OVS) + 3;
      check(cnt >= expc - tol && cnt <= expc + tol, "R3 bit time", cnt, expc);
      idle(2 * CLK_HZ / rate_of(s));
      rreg(3'd0, 1, d); check(d == 8'h00, "R3 byte at rate", d, 0);
    end
    wreg(3'd1, 8'd31);
    rreg(3'd1, 0, d); check(d == 8'd31, "R3 code readback", d, 31);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule